// File: doc/BRIEF.md
# Control-Flow Target and Stack Step Unit

This block works out, for one control-flow decision of a 16-bit processor, where the program counter goes next and how the stack pointer moves. Each request names an instruction kind: sequential, jump, branch, absolute call, relative call, return, push or pop. It also carries a 3-bit mask that selects which flags matter and a 3-bit field that gives the value those flags must have. Alongside these come the current carry, zero and negative flags, the address of the opcode, the immediate word that follows the opcode, the stack pointer, the word read from the stack, and the word to push.

One clock edge after a request is accepted, the block presents its result. The result holds the next program counter, a flag saying control was transferred, the updated stack pointer, and the stack address. It also carries read and write strobes for the stack access and the data to write. The unit only forms the address and the data; the memory access itself happens outside the block.

Conditions are tested with a generic mask-and-compare over the flags. Calls, returns, pushes and pops move the stack pointer by one word of two bytes. All address arithmetic wraps at the data width.

Top module: `ctl_flow_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output register clears to zero, including `out_valid`, `out_next_pc`, `out_sp`, `out_stk_addr`, `out_stk_we`, `out_stk_re` and `out_stk_wdata`.
- R2: The flags are packed with carry at bit 2, zero at bit 1 and negative at bit 0. A jump or branch is taken exactly when `(flags & care) == pol`. An all-zero mask with an all-zero polarity is always taken. A polarity bit set outside the mask means the transfer is never taken.
- R3: A jump (kind 1) that is taken sets the next PC to the immediate word. A jump that is not taken sets it to PC+4, the address past the immediate. The stack pointer stays unchanged, the stack address equals it, and neither strobe is raised.
- R4: A branch (kind 2) that is taken sets the next PC to (PC+4)+immediate. A branch that is not taken sets it to PC+4. The stack pointer is unchanged and neither strobe is raised.
- R5: An absolute call (kind 3) or a relative call (kind 4) ignores the condition and is always taken. It sets the stack pointer and the stack address to SP-2, raises the write strobe and writes PC+4. The next PC is the immediate word for kind 3 and (PC+4)+immediate for kind 4.
- R6: A return (kind 5) is always taken. The next PC is the popped word, the stack address is SP, the read strobe is raised and the new stack pointer is SP+2.
- R7: A push (kind 6) sets the stack pointer and the stack address to SP-2, raises the write strobe and writes the push data. The next PC is PC+2 and the transfer flag stays low.
- R8: A pop (kind 7) uses SP as the stack address, raises the read strobe and sets the new stack pointer to SP+2. The next PC is PC+2 and the transfer flag stays low.
- R9: A sequential request (kind 0) sets the next PC to PC+2 whatever the mask, polarity and flags are. The stack pointer is unchanged, the stack address equals SP, both strobes are low and the transfer flag is low. Whenever the write strobe is low, the write data is zero.
- R10: All PC and stack-pointer arithmetic wraps modulo 2^16.
- R11: The result of a request accepted at a rising edge with `in_valid` high appears after that edge, with `out_valid` high. When `in_valid` is low at an edge, `out_valid` goes low and the other outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 3 | Instruction kind, encoded 0 to 7 as listed in the requirements |
| in_care | input | 3 | Flag mask selecting which flags are tested |
| in_pol | input | 3 | Required values of the masked flags |
| in_flags | input | 3 | Current flags: carry bit 2, zero bit 1, negative bit 0 |
| in_pc | input | 16 | Address of the opcode |
| in_imm | input | 16 | Immediate word following the opcode |
| in_sp | input | 16 | Current stack pointer |
| in_pop_data | input | 16 | Word read from the stack (return address) |
| in_push_data | input | 16 | Register value to push |
| out_valid | output | 1 | Result valid |
| out_next_pc | output | 16 | Next program counter |
| out_taken | output | 1 | Control transferred |
| out_sp | output | 16 | Updated stack pointer |
| out_stk_addr | output | 16 | Stack access address |
| out_stk_we | output | 1 | Stack write strobe |
| out_stk_re | output | 1 | Stack read strobe |
| out_stk_wdata | output | 16 | Stack write data |

## Verification
The bench builds the unit with its defaults: 16-bit words, a 3-bit flag field, a stack step of 2 and 2-byte instruction words. With a 3-bit flag field, every combination of mask, polarity and flags for jumps (512 cases) and a sweep for branches can be run in full. With a 16-bit width, the wrap of the program counter and the stack pointer across 0xFFFF can be reached with a handful of requests placed near the top and bottom of the address space.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        FK_SEQ      = 3'd0,
        FK_JUMP     = 3'd1,
        FK_BRANCH   = 3'd2,
        FK_CALL_ABS = 3'd3,
        FK_CALL_REL = 3'd4,
        FK_RETURN   = 3'd5,
        FK_PUSH     = 3'd6,
        FK_POP      = 3'd7
    } flow_kind_e;

    typedef enum logic [2:0] {
        PCS_SEQ  = 3'd0,
        PCS_SKIP = 3'd1,
        PCS_ABS  = 3'd2,
        PCS_REL  = 3'd3,
        PCS_POP  = 3'd4
    } pc_sel_e;

    typedef enum logic [1:0] {
        SPM_HOLD = 2'd0,
        SPM_DEC  = 2'd1,
        SPM_INC  = 2'd2
    } sp_mode_e;

    typedef struct packed {
        pc_sel_e  pc_sel;
        sp_mode_e sp_mode;
        logic     stk_we;
        logic     stk_re;
        logic     taken;
        logic     wd_ret;
    } flow_ctl_t;

    function automatic logic is_call(flow_kind_e k);
        return (k == FK_CALL_ABS) || (k == FK_CALL_REL);
    endfunction

    function automatic flow_ctl_t decode_flow(flow_kind_e k, logic cond_ok);
        flow_ctl_t c;
        c.pc_sel  = PCS_SEQ;
        c.sp_mode = SPM_HOLD;
        c.stk_we  = 1'b0;
        c.stk_re  = 1'b0;
        c.taken   = 1'b0;
        c.wd_ret  = 1'b0;
        case (k)
            FK_JUMP: begin
                c.taken  = cond_ok;
                c.pc_sel = cond_ok ? PCS_ABS : PCS_SKIP;
            end
            FK_BRANCH: begin
                c.taken  = cond_ok;
                c.pc_sel = cond_ok ? PCS_REL : PCS_SKIP;
            end
            FK_CALL_ABS, FK_CALL_REL: begin
                c.pc_sel  = (k == FK_CALL_ABS) ? PCS_ABS : PCS_REL;
                c.sp_mode = SPM_DEC;
                c.stk_we  = 1'b1;
                c.taken   = 1'b1;
                c.wd_ret  = 1'b1;
            end
            FK_RETURN: begin
                c.pc_sel  = PCS_POP;
                c.sp_mode = SPM_INC;
                c.stk_re  = 1'b1;
                c.taken   = 1'b1;
            end
            FK_PUSH: begin
                c.sp_mode = SPM_DEC;
                c.stk_we  = 1'b1;
            end
            FK_POP: begin
                c.sp_mode = SPM_INC;
                c.stk_re  = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval #(
    parameter int unsigned FLAG_W = 3
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] care,
    input  logic [FLAG_W-1:0] pol,
    output logic              cond_ok
);
    logic [FLAG_W-1:0] bit_ok;

    // A masked bit must equal its polarity; an unmasked bit requires polarity 0.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assign bit_ok[i] = care[i] ? (flags[i] == pol[i]) : ~pol[i];
    end

    assign cond_ok = &bit_ok;
endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned OPC_BYTES = 2
) (
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] pop_data,
    input  pc_sel_e           sel,
    output logic [DATA_W-1:0] next_pc,
    output logic [DATA_W-1:0] ret_pc
);
    localparam logic [DATA_W-1:0] SEQ_INC  = DATA_W'(OPC_BYTES);
    localparam logic [DATA_W-1:0] SKIP_INC = DATA_W'(2 * OPC_BYTES);

    logic [DATA_W-1:0] seq_pc;
    logic [DATA_W-1:0] rel_pc;

    assign seq_pc = pc + SEQ_INC;
    assign ret_pc = pc + SKIP_INC;
    assign rel_pc = ret_pc + imm;

    always_comb begin
        case (sel)
            PCS_SKIP: next_pc = ret_pc;
            PCS_ABS:  next_pc = imm;
            PCS_REL:  next_pc = rel_pc;
            PCS_POP:  next_pc = pop_data;
            default:  next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/pcu_stack_adj.sv
module pcu_stack_adj
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SP_STEP = 2
) (
    input  logic [DATA_W-1:0] sp,
    input  sp_mode_e          mode,
    input  logic              we,
    input  logic              wd_ret,
    input  logic [DATA_W-1:0] ret_pc,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] sp_next,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(SP_STEP);

    logic [DATA_W-1:0] sp_dec;
    logic [DATA_W-1:0] sp_inc;

    assign sp_dec = sp - STEP;
    assign sp_inc = sp + STEP;

    always_comb begin
        case (mode)
            SPM_DEC: sp_next = sp_dec;
            SPM_INC: sp_next = sp_inc;
            default: sp_next = sp;
        endcase
    end

    // Pre-decrement writes at the new top; post-increment reads at the old top.
    assign addr  = (mode == SPM_DEC) ? sp_dec : sp;
    assign wdata = !we ? '0 : (wd_ret ? ret_pc : push_data);
endmodule

// File: rtl/ctl_flow_unit.sv
module ctl_flow_unit
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned FLAG_W    = 3,
    parameter int unsigned SP_STEP   = 2,
    parameter int unsigned OPC_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_kind,
    input  logic [FLAG_W-1:0] in_care,
    input  logic [FLAG_W-1:0] in_pol,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic [DATA_W-1:0] in_pc,
    input  logic [DATA_W-1:0] in_imm,
    input  logic [DATA_W-1:0] in_sp,
    input  logic [DATA_W-1:0] in_pop_data,
    input  logic [DATA_W-1:0] in_push_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_next_pc,
    output logic              out_taken,
    output logic [DATA_W-1:0] out_sp,
    output logic [DATA_W-1:0] out_stk_addr,
    output logic              out_stk_we,
    output logic              out_stk_re,
    output logic [DATA_W-1:0] out_stk_wdata
);
    localparam logic [DATA_W-1:0] SP_INC   = DATA_W'(SP_STEP);
    localparam logic [DATA_W-1:0] SKIP_INC = DATA_W'(2 * OPC_BYTES);

    flow_kind_e        kind;
    logic              cond_ok;
    flow_ctl_t         ctl;
    logic [DATA_W-1:0] nxt_pc;
    logic [DATA_W-1:0] ret_pc;
    logic [DATA_W-1:0] nxt_sp;
    logic [DATA_W-1:0] stk_addr;
    logic [DATA_W-1:0] stk_wdata;

    assign kind = flow_kind_e'(in_kind);

    pcu_cond_eval #(.FLAG_W(FLAG_W)) u_cond (
        .flags   (in_flags),
        .care    (in_care),
        .pol     (in_pol),
        .cond_ok (cond_ok)
    );

    always_comb ctl = decode_flow(kind, cond_ok);

    pcu_target_gen #(.DATA_W(DATA_W), .OPC_BYTES(OPC_BYTES)) u_tgt (
        .pc       (in_pc),
        .imm      (in_imm),
        .pop_data (in_pop_data),
        .sel      (ctl.pc_sel),
        .next_pc  (nxt_pc),
        .ret_pc   (ret_pc)
    );

    pcu_stack_adj #(.DATA_W(DATA_W), .SP_STEP(SP_STEP)) u_stk (
        .sp        (in_sp),
        .mode      (ctl.sp_mode),
        .we        (ctl.stk_we),
        .wd_ret    (ctl.wd_ret),
        .ret_pc    (ret_pc),
        .push_data (in_push_data),
        .sp_next   (nxt_sp),
        .addr      (stk_addr),
        .wdata     (stk_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_next_pc   <= '0;
            out_taken     <= 1'b0;
            out_sp        <= '0;
            out_stk_addr  <= '0;
            out_stk_we    <= 1'b0;
            out_stk_re    <= 1'b0;
            out_stk_wdata <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_next_pc   <= nxt_pc;
                out_taken     <= ctl.taken;
                out_sp        <= nxt_sp;
                out_stk_addr  <= stk_addr;
                out_stk_we    <= ctl.stk_we;
                out_stk_re    <= ctl.stk_re;
                out_stk_wdata <= stk_wdata;
            end
        end
    end

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_next_pc) && $stable(out_sp))); // R11
    AST_UNCOND_JUMP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == FK_JUMP && in_care == '0 && in_pol == '0)
        |=> (out_taken && out_next_pc == $past(in_imm))); // R2
    AST_CALL_SAVES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_call(kind))
        |=> (out_taken && out_stk_we && out_stk_wdata == $past(in_pc) + SKIP_INC)); // R5
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == FK_RETURN)
        |=> (out_taken && out_stk_re && out_next_pc == $past(in_pop_data))); // R6
    AST_WRITE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stk_we) |-> (out_sp == out_stk_addr)); // R7
    AST_READ_BELOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stk_re) |-> (out_sp == out_stk_addr + SP_INC)); // R8
    AST_SEQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == FK_SEQ)
        |=> (!out_taken && !out_stk_we && !out_stk_re && out_sp == $past(in_sp))); // R9
endmodule

// File: tb/sim_ctl_flow_unit.sv
module sim_ctl_flow_unit;

    typedef struct {
        logic [15:0] next_pc;
        logic        taken;
        logic [15:0] sp;
        logic [15:0] addr;
        logic        we;
        logic        re;
        logic [15:0] wdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_kind = '0;
    logic [2:0]  in_care = '0;
    logic [2:0]  in_pol = '0;
    logic [2:0]  in_flags = '0;
    logic [15:0] in_pc = '0;
    logic [15:0] in_imm = '0;
    logic [15:0] in_sp = '0;
    logic [15:0] in_pop_data = '0;
    logic [15:0] in_push_data = '0;
    logic        out_valid;
    logic [15:0] out_next_pc;
    logic        out_taken;
    logic [15:0] out_sp;
    logic [15:0] out_stk_addr;
    logic        out_stk_we;
    logic        out_stk_re;
    logic [15:0] out_stk_wdata;

    int   n_chk = 0;
    int   n_fail = 0;
    logic [15:0] last_next = '0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    ctl_flow_unit u0 (
        .clk, .rst, .in_valid, .in_kind, .in_care, .in_pol, .in_flags,
        .in_pc, .in_imm, .in_sp, .in_pop_data, .in_push_data,
        .out_valid, .out_next_pc, .out_taken, .out_sp, .out_stk_addr,
        .out_stk_we, .out_stk_re, .out_stk_wdata
    );

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(logic [2:0] k, logic [2:0] care, logic [2:0] pol,
                                   logic [2:0] fl, logic [15:0] pc, logic [15:0] imm,
                                   logic [15:0] sp, logic [15:0] popd, logic [15:0] pushd,
                                   string tag);
        exp_t e;
        logic [15:0] past;
        logic ok;
        past = pc + 16'd4;
        ok = ((fl & care) == pol);
        e.next_pc = pc + 16'd2;
        e.taken = 1'b0;
        e.sp = sp;
        e.addr = sp;
        e.we = 1'b0;
        e.re = 1'b0;
        e.wdata = 16'h0;
        e.tag = tag;
        case (k)
            3'd1: begin e.taken = ok; e.next_pc = ok ? imm : past; end
            3'd2: begin e.taken = ok; e.next_pc = ok ? past + imm : past; end
            3'd3, 3'd4: begin
                e.taken = 1'b1;
                e.next_pc = (k == 3'd3) ? imm : past + imm;
                e.sp = sp - 16'd2; e.addr = sp - 16'd2;
                e.we = 1'b1; e.wdata = past;
            end
            3'd5: begin
                e.taken = 1'b1; e.next_pc = popd;
                e.re = 1'b1; e.sp = sp + 16'd2;
            end
            3'd6: begin
                e.sp = sp - 16'd2; e.addr = sp - 16'd2;
                e.we = 1'b1; e.wdata = pushd;
            end
            3'd7: begin e.re = 1'b1; e.sp = sp + 16'd2; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(logic [2:0] k, logic [2:0] care, logic [2:0] pol, logic [2:0] fl,
                         logic [15:0] pc, logic [15:0] imm, logic [15:0] sp,
                         logic [15:0] popd, logic [15:0] pushd, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_kind = k; in_care = care; in_pol = pol; in_flags = fl;
        in_pc = pc; in_imm = imm; in_sp = sp;
        in_pop_data = popd; in_push_data = pushd;
        sb_q.push_back(model(k, care, pol, fl, pc, imm, sp, popd, pushd, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_kind = 3'd5; in_pop_data = 16'hDEAD; in_sp = 16'h1111;
    endtask

    // Monitor: pops expected items as results appear.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R11", "unexpected result", 16'(out_valid), 16'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, "next_pc", out_next_pc, e.next_pc);
                    check(e.tag, "taken", 16'(out_taken), 16'(e.taken));
                    check(e.tag, "sp", out_sp, e.sp);
                    check(e.tag, "stk_addr", out_stk_addr, e.addr);
                    check(e.tag, "stk_we", 16'(out_stk_we), 16'(e.we));
                    check(e.tag, "stk_re", 16'(out_stk_re), 16'(e.re));
                    check(e.tag, "stk_wdata", out_stk_wdata, e.wdata);
                    last_next = e.next_pc;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "out_valid", 16'(out_valid), 16'h0);
        check("R1", "out_next_pc", out_next_pc, 16'h0);
        check("R1", "out_sp", out_sp, 16'h0);
        check("R1", "out_stk_we", 16'(out_stk_we), 16'h0);
        check("R1", "out_stk_wdata", out_stk_wdata, 16'h0);

        // R9: sequential ignores condition fields
        drive(3'd0, 3'b111, 3'b101, 3'b010, 16'h0100, 16'h5555, 16'h8000, 16'h0, 16'h0, "R9");
        drive(3'd0, 3'b000, 3'b111, 3'b000, 16'hFFFE, 16'h0, 16'h0042, 16'h0, 16'h0, "R10");
        // R2/R3: jump conditions
        drive(3'd1, 3'b000, 3'b000, 3'b111, 16'h0200, 16'h3000, 16'h7000, 16'h0, 16'h0, "R2");
        drive(3'd1, 3'b000, 3'b001, 3'b111, 16'h0200, 16'h3000, 16'h7000, 16'h0, 16'h0, "R2");
        drive(3'd1, 3'b010, 3'b010, 3'b010, 16'h0210, 16'h4000, 16'h7000, 16'h0, 16'h0, "R3");
        drive(3'd1, 3'b010, 3'b010, 3'b101, 16'h0210, 16'h4000, 16'h7000, 16'h0, 16'h0, "R3");
        drive(3'd1, 3'b100, 3'b000, 3'b100, 16'h0220, 16'h4400, 16'h7000, 16'h0, 16'h0, "R2");
        drive(3'd1, 3'b001, 3'b011, 3'b111, 16'h0230, 16'h4800, 16'h7000, 16'h0, 16'h0, "R2");
        // R4/R10: branches
        drive(3'd2, 3'b000, 3'b000, 3'b000, 16'h1000, 16'hFFF0, 16'h6000, 16'h0, 16'h0, "R4");
        drive(3'd2, 3'b001, 3'b001, 3'b000, 16'h1000, 16'h0100, 16'h6000, 16'h0, 16'h0, "R4");
        drive(3'd2, 3'b000, 3'b000, 3'b000, 16'hFFFE, 16'h0000, 16'h6000, 16'h0, 16'h0, "R10");
        // R5: calls ignore condition
        drive(3'd3, 3'b111, 3'b000, 3'b111, 16'h0200, 16'h3000, 16'h8000, 16'h0, 16'h0, "R5");
        drive(3'd4, 3'b111, 3'b000, 3'b111, 16'h0300, 16'h0010, 16'h0000, 16'h0, 16'h0, "R5");
        // R6: returns
        drive(3'd5, 3'b000, 3'b001, 3'b000, 16'h0400, 16'h0, 16'h7FFE, 16'h1234, 16'h0, "R6");
        drive(3'd5, 3'b000, 3'b000, 3'b000, 16'h0400, 16'h0, 16'hFFFE, 16'hABCD, 16'h0, "R10");
        // R7/R8: push and pop
        drive(3'd6, 3'b000, 3'b000, 3'b000, 16'h0040, 16'h0, 16'h0100, 16'h0, 16'hBEEF, "R7");
        drive(3'd7, 3'b000, 3'b000, 3'b000, 16'h0042, 16'h0, 16'h00FE, 16'h9999, 16'h0, "R8");
        drive(3'd6, 3'b000, 3'b000, 3'b000, 16'h0044, 16'h0, 16'h0000, 16'h0, 16'h5A5A, "R10");

        // R2: exhaustive mask/polarity/flags for jumps, sweep for branches
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 8; p++)
                for (int f = 0; f < 8; f++)
                    drive(3'd1, 3'(c), 3'(p), 3'(f), 16'(16'h2000 + 16'(f * 2)),
                          16'(16'h0C00 + 16'(c * 16 + p)), 16'h5000, 16'h0, 16'h0, "R2");
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 8; f++)
                drive(3'd2, 3'(c), 3'(c & 5), 3'(f), 16'hFFF0, 16'(16'h0020 + 16'(c)),
                      16'h5000, 16'h0, 16'h0, "R4");

        // R11: idle keeps outputs
        idle();
        repeat (3) @(negedge clk);
        check("R11", "queue drained", 16'(sb_q.size()), 16'h0);
        check("R11", "out_valid idle", 16'(out_valid), 16'h0);
        check("R11", "next_pc held", out_next_pc, last_next);
        check("R11", "sp held", out_sp, 16'h5000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule